// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

This block is a software-supervised watchdog. Firmware arms it by loading a tick count into the count register and choosing an expiry action in the control register. Each pulse on the tick-enable input lowers the count by one. When the count steps down to zero, the block raises the chosen response: nothing, a level interrupt, a level non-maskable interrupt, or a one-cycle request for a full-chip reset. Healthy firmware writes the count register again before it runs out. Each such write is a keepalive that restarts the countdown.

A sticky reset-cause flag records that the last chip reset came from the watchdog. It sits on a separate power-on reset, so the functional reset that the watchdog itself causes leaves it intact. Firmware reads it after boot. The register port is a plain single-cycle write strobe plus a read strobe whose data arrives one cycle later. The port never stalls, so it has no back-pressure and no ready signal. Every access completes in the cycle it is issued.

Top module: `wdog_timer`

## Requirements
- R1: While `rst_n` is low and after it rises, the count is 0, the action is 0, and `irq_gp`, `irq_nmi`, `rst_req` and `reg_rvalid` are low.
- R2: A write with `reg_addr`=0 loads `reg_wdata` into the count. Reading address 0 returns the current count. A load in the same cycle as a tick takes priority over the decrement.
- R3: Each cycle with `tick_en` high and no load lowers a nonzero count by exactly one. A count of zero stays at zero and never wraps.
- R4: Expiry happens only when a tick lowers the count from 1 to 0. Loading 0 directly, or ticking a count that is already 0, causes no expiry.
- R5: On expiry with action 1, `irq_gp` rises at the same clock edge where the count becomes 0. It stays high until a count load, or until a control write with action 0.
- R6: On expiry with action 2, `irq_nmi` behaves in the same way as `irq_gp` does for action 1.
- R7: On expiry with action 3, `rst_req` is high for exactly one cycle, and the reset-cause flag is set at the same edge.
- R8: With action 0 (disarmed), expiry drives no output. While the action is 0, both interrupts are low.
- R9: The reset-cause flag reads as bit 31 of the control register. Only `por_n` clears it: `rst_n` leaves it unchanged, and software writes to bit 31 have no effect.
- R10: A write with `reg_addr`=1 stores `reg_wdata[1:0]` as the action (0 none, 1 interrupt, 2 NMI, 3 chip reset). A control read returns the action in bits [1:0] and the flag in bit 31, with bits [30:2] always 0 whatever was written there.
- R11: `reg_re` high in cycle N gives `reg_rvalid` high in cycle N+1, together with the register value as it stood before the edge that ends cycle N. Without a read, `reg_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears the reset-cause flag |
| rst_n | input | 1 | Functional reset, active low |
| tick_en | input | 1 | One watchdog tick per high cycle |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = count register, 1 = control register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_re |
| irq_gp | output | 1 | General-purpose interrupt level |
| irq_nmi | output | 1 | Non-maskable interrupt level |
| rst_req | output | 1 | One-cycle full-chip reset request |

## Verification
The bench targets the off-by-one edges of the countdown:
- A design that fires on a count loaded as 0 would raise an interrupt without any tick.
- A design that fires at 1 instead of at the step to 0 would be a cycle early.
- A design that wraps at zero would read back 0xFFFFFFFF.

It pushes a keepalive into the same cycle as a tick, and a read into the same cycle as a write. A design with the wrong priority or read timing would return the decremented count or the new value.

It also checks that a functional reset keeps the cause flag while a power-on reset clears it, and that a write of 1 to bit 31 cannot forge the flag. Finally, it checks that a disarm write drops a pending interrupt, while changing to another nonzero action leaves it up.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ACT_W = 2;

  typedef enum logic [ACT_W-1:0] {
    ACT_NONE    = 2'd0,
    ACT_IRQ     = 2'd1,
    ACT_NMI     = 2'd2,
    ACT_CHIPRST = 2'd3
  } wdog_act_e;

  localparam logic ADDR_COUNT = 1'b0;
  localparam logic ADDR_CTRL  = 1'b1;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             nonzero;

  assign nonzero  = |cnt_q;
  // expiry only on a tick stepping 1 -> 0; a load overrides the tick
  assign expire_o = tick_i && !load_i && (cnt_q == CNT_W'(1));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (tick_i && nonzero) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_o == $past(load_val_i));
  assert_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && cnt_o != '0) |=> cnt_o == $past(cnt_o) - CNT_W'(1));
  assert_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_o == '0) |=> cnt_o == '0);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !tick_i) |=> $stable(cnt_o));
  assert_expire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> cnt_o == '0);
endmodule

// File: rtl/wdog_regport.sv
module wdog_regport
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              re_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              cause_i,
  output logic              load_o,
  output logic [DATA_W-1:0] load_val_o,
  output wdog_act_e         act_o,
  output logic              disarm_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam int PAD_W = DATA_W - 1 - ACT_W;

  wdog_act_e         act_q;
  logic              ctrl_we;
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  assign ctrl_we    = we_i && (addr_i == ADDR_CTRL);
  assign load_o     = we_i && (addr_i == ADDR_COUNT);
  assign load_val_o = wdata_i;
  assign disarm_o   = ctrl_we && (wdata_i[ACT_W-1:0] == ACT_NONE);
  assign ctrl_word  = {cause_i, PAD_W'(0), act_q};
  assign act_o      = act_q;
  assign rdata_o    = rdata_q;
  assign rvalid_o   = rvalid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= ACT_NONE;
    end else if (ctrl_we) begin
      act_q <= wdog_act_e'(wdata_i[ACT_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= re_i;
      if (re_i) begin
        rdata_q <= (addr_i == ADDR_CTRL) ? ctrl_word : cnt_i;
      end
    end
  end

  assert_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    re_i |=> rvalid_o);
  assert_no_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !re_i |=> !rvalid_o);
  assert_ctrl_pad_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (re_i && addr_i == ADDR_CTRL) |=> rdata_o[DATA_W-2:ACT_W] == '0);
endmodule

// File: rtl/wdog_action.sv
module wdog_action
  import wdog_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      por_n,
  input  logic      expire_i,
  input  wdog_act_e act_i,
  input  logic      load_i,
  input  logic      disarm_i,
  output logic      irq_gp_o,
  output logic      irq_nmi_o,
  output logic      rst_req_o,
  output logic      cause_o
);
  localparam int N_IRQ = 2;

  logic [N_IRQ-1:0] irq_lvl;
  logic             rst_req_q;
  logic             cause_q;
  logic             fire_rst;

  // channel g serves action g+1 (interrupt, then NMI)
  for (genvar g = 0; g < N_IRQ; g++) begin : g_irq
    logic lvl_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q <= 1'b0;
      end else if (load_i || disarm_i) begin
        lvl_q <= 1'b0;
      end else if (expire_i && act_i == wdog_act_e'(g + 1)) begin
        lvl_q <= 1'b1;
      end
    end
    assign irq_lvl[g] = lvl_q;
  end

  assign fire_rst = expire_i && (act_i == ACT_CHIPRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= fire_rst;
    end
  end

  // reset-cause flag lives on the power-on domain only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cause_q <= 1'b0;
    end else if (fire_rst) begin
      cause_q <= 1'b1;
    end
  end

  assign irq_gp_o  = irq_lvl[0];
  assign irq_nmi_o = irq_lvl[1];
  assign rst_req_o = rst_req_q;
  assign cause_o   = cause_q;

  assert_irq_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_gp_o, irq_nmi_o}));
  assert_irq_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !irq_gp_o && !irq_nmi_o);
  assert_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_NONE) |-> (!irq_gp_o && !irq_nmi_o));
  assert_rst_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);
  assert_cause_set_R7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    rst_req_o |-> cause_o);
  assert_cause_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
    cause_o |=> cause_o);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  output logic              irq_gp,
  output logic              irq_nmi,
  output logic              rst_req
);
  logic              load;
  logic [DATA_W-1:0] load_val;
  logic [DATA_W-1:0] cnt;
  logic              expire;
  logic              disarm;
  logic              cause;
  wdog_act_e         act;

  wdog_regport #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (reg_we),
    .re_i       (reg_re),
    .addr_i     (reg_addr),
    .wdata_i    (reg_wdata),
    .cnt_i      (cnt),
    .cause_i    (cause),
    .load_o     (load),
    .load_val_o (load_val),
    .act_o      (act),
    .disarm_o   (disarm),
    .rdata_o    (reg_rdata),
    .rvalid_o   (reg_rvalid)
  );

  wdog_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (load_val),
    .tick_i     (tick_en),
    .cnt_o      (cnt),
    .expire_o   (expire)
  );

  wdog_action u_act (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_n     (por_n),
    .expire_i  (expire),
    .act_i     (act),
    .load_i    (load),
    .disarm_i  (disarm),
    .irq_gp_o  (irq_gp),
    .irq_nmi_o (irq_nmi),
    .rst_req_o (rst_req),
    .cause_o   (cause)
  );
endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        irq_gp, irq_nmi, rst_req;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  // reference model state
  logic [31:0] m_cnt;
  logic [1:0]  m_act;
  logic        m_gp, m_nmi, m_rst, m_flag;

  always #4 clk = ~clk;

  wdog_timer u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_en(tick_en),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .irq_gp(irq_gp), .irq_nmi(irq_nmi), .rst_req(rst_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ctrl_word(input logic flag, input logic [1:0] a);
    return {flag, 29'd0, a};
  endfunction

  task automatic step(input logic we, input logic addr, input logic [31:0] wd,
                      input logic re, input logic tk, input string tag);
    logic        ld, cw, expd;
    logic [31:0] e_rd;
    logic [31:0] n_cnt;
    logic [1:0]  n_act;
    logic        n_gp, n_nmi, n_rst;
    @(negedge clk);
    reg_we = we; reg_addr = addr; reg_wdata = wd; reg_re = re; tick_en = tk;
    ld   = we && !addr;
    cw   = we && addr;
    expd = !ld && tk && (m_cnt == 32'd1);
    e_rd = addr ? ctrl_word(m_flag, m_act) : m_cnt;
    n_cnt = ld ? wd : ((tk && m_cnt != 0) ? m_cnt - 32'd1 : m_cnt);
    n_act = cw ? wd[1:0] : m_act;
    n_gp  = (ld || (cw && wd[1:0] == 2'd0)) ? 1'b0 : ((expd && m_act == 2'd1) ? 1'b1 : m_gp);
    n_nmi = (ld || (cw && wd[1:0] == 2'd0)) ? 1'b0 : ((expd && m_act == 2'd2) ? 1'b1 : m_nmi);
    n_rst = expd && (m_act == 2'd3);
    @(posedge clk);
    #1;
    m_cnt = n_cnt; m_act = n_act; m_gp = n_gp; m_nmi = n_nmi; m_rst = n_rst;
    m_flag = m_flag | n_rst;
    check("R5 irq_gp", {31'd0, irq_gp}, {31'd0, m_gp});
    check("R6 irq_nmi", {31'd0, irq_nmi}, {31'd0, m_nmi});
    check("R7 rst_req", {31'd0, rst_req}, {31'd0, m_rst});
    check("R11 rvalid", {31'd0, reg_rvalid}, {31'd0, re});
    if (re) check(tag, reg_rdata, e_rd);
  endtask

  task automatic do_reset(input bit power_on);
    @(negedge clk);
    rst_n = 1'b0;
    if (power_on) por_n = 1'b0;
    reg_we = 0; reg_re = 0; tick_en = 0;
    repeat (2) @(negedge clk);
    check("R1 irq_gp in reset", {31'd0, irq_gp}, 32'd0);
    check("R1 rst_req in reset", {31'd0, rst_req}, 32'd0);
    rst_n = 1'b1; por_n = 1'b1;
    m_cnt = 0; m_act = 0; m_gp = 0; m_nmi = 0; m_rst = 0;
    if (power_on) m_flag = 0;
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    m_flag = 0;
    do_reset(1);
    // R1 reset state through the port
    step(0, 1, 0, 1, 0, "R1 ctrl after reset");
    step(0, 0, 0, 1, 0, "R1 count after reset");
    check("R1 irq_nmi after reset", {31'd0, irq_nmi}, 32'd0);

    // R10 action 1 with junk upper bits and bit 31 set; R9 flag not forged
    step(1, 1, 32'hFFFF_FFFD, 0, 0, "R10");
    step(0, 1, 0, 1, 0, "R10 R9 ctrl readback");
    step(1, 0, 32'd5, 0, 0, "R2");
    step(0, 0, 0, 1, 0, "R2 count readback");
    ticks(4, "R3");
    step(0, 0, 0, 1, 0, "R3 count at 1");
    check("R4 no early expiry", {31'd0, irq_gp}, 32'd0);
    step(0, 0, 0, 0, 1, "R5");
    check("R5 irq_gp raised", {31'd0, irq_gp}, 32'd1);
    ticks(3, "R3 floor");
    step(0, 0, 0, 1, 0, "R3 floor readback");
    step(1, 1, 32'd2, 0, 0, "R5 change to NMI keeps gp");
    check("R5 gp held", {31'd0, irq_gp}, 32'd1);
    step(1, 1, 32'd0, 0, 0, "R8 disarm");
    check("R8 disarm clears gp", {31'd0, irq_gp}, 32'd0);

    // R4 load 0 directly: no expiry
    step(1, 1, 32'd1, 0, 0, "R4");
    step(1, 0, 32'd0, 0, 1, "R4 load zero");
    ticks(3, "R4");
    check("R4 no expiry from loaded 0", {31'd0, irq_gp}, 32'd0);

    // R2 load priority over tick, read same cycle as write
    step(1, 0, 32'hFFFF_FFFF, 1, 1, "R11 read old value");
    ticks(3, "R3");
    step(0, 0, 0, 1, 0, "R3 no wrap high count");
    check("R3 count 0xFFFFFFFC", reg_rdata, 32'hFFFF_FFFC);

    // R6 NMI path
    step(1, 1, 32'd2, 0, 0, "R6");
    step(1, 0, 32'd3, 0, 0, "R6");
    ticks(5, "R6");
    check("R6 nmi raised", {31'd0, irq_nmi}, 32'd1);
    step(1, 0, 32'd9, 0, 0, "R6 reload clears");
    check("R6 reload clears nmi", {31'd0, irq_nmi}, 32'd0);

    // R8 disarmed expiry does nothing
    step(1, 1, 32'd0, 0, 0, "R8");
    step(1, 0, 32'd2, 0, 0, "R8");
    ticks(4, "R8");
    check("R8 no outputs", {29'd0, irq_gp, irq_nmi, rst_req}, 32'd0);

    // R7 chip reset action, R9 flag across functional reset
    step(1, 1, 32'd3, 0, 0, "R7");
    step(1, 0, 32'd2, 0, 0, "R7");
    step(0, 0, 0, 0, 1, "R7");
    step(0, 0, 0, 0, 1, "R7");
    check("R7 rst_req pulse", {31'd0, rst_req}, 32'd1);
    step(0, 0, 0, 0, 1, "R7");
    check("R7 pulse one cycle", {31'd0, rst_req}, 32'd0);
    do_reset(0);
    step(0, 1, 0, 1, 0, "R9 flag survives rst_n");
    check("R9 bit31 set", {31'd0, reg_rdata[31]}, 32'd1);
    step(1, 1, 32'd0, 0, 0, "R9");
    step(0, 1, 0, 1, 0, "R9 write cannot clear flag");
    do_reset(1);
    step(0, 1, 0, 1, 0, "R9 por clears flag");
    check("R9 bit31 clear", {31'd0, reg_rdata[31]}, 32'd0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic we, addr, re, tk;
      logic [31:0] wd;
      r    = $urandom % 100;
      we   = (r < 12);
      addr = $urandom % 2;
      wd   = addr ? $urandom : (($urandom % 8 == 0) ? $urandom : $urandom % 12);
      re   = ($urandom % 10) < 3;
      tk   = ($urandom % 10) < 6;
      step(we, addr, wd, re, tk, addr ? "R10 R9 random ctrl" : "R2 R3 random count");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule